// File: doc/BRIEF.md
# Real-Time-Clock Register Write Guard

This block sits on the write path between a simple register bus and the register file of a real-time clock. It decides, for every bus write, which bits of the addressed register may change. The decision rests on four things: a lock state, an initialization-mode flag, the register being written, and three status inputs. The status inputs report whether the wakeup timer may be written, whether the alarms may be written, and whether a clock trim adjustment is still in progress. A small model register file is included so that the effect of each decision can be read back.

The lock opens only after a two-byte key sequence is written, in order, to a dedicated key slot. The lock state has its own power-on reset. The ordinary system reset clears the model registers but does not touch the lock. Writes that are refused entirely leave the register untouched and raise a one-cycle observation pulse. Writes that are only partly allowed update the permitted bits and keep the rest.

Top module: `rtcwp_gate`

## Requirements
- R1: While `por_rst` is high, and in the cycle after it is released, `locked` is 1, `wr_drop` is 0 and every slot reads 0.
- R2: `sys_rst` clears every model slot (including the initialization bit) and `wr_drop`, and leaves the lock state and the key-sequence progress as they were.
- R3: Writing low byte 0xCA to slot 8 and then low byte 0x53 to slot 8 on the next bus write clears `locked` in the cycle after the second write. Bits above the low byte of a key write are ignored.
- R4: A key write whose low byte is neither 0xCA nor a correctly placed 0x53 sets `locked`. A 0xCA key write while unlocked also locks and starts a new sequence.
- R5: After a 0xCA key write, any bus write other than a 0x53 key write returns the sequence to idle, so the block stays locked. This includes a second 0xCA and writes to other slots.
- R6: Slot 10 (tamper) and slots 11 to 10+NUM_BKP (backup) always accept writes. Slot 3 (status) accepts bits 14 to 8 while locked and all bits while unlocked.
- R7: Slots 0 (time), 1 (date) and 4 (divider) accept writes only when unlocked and initialization mode is active. Initialization mode is bit 0 of slot 3 and is reported on `init_active`.
- R8: Slot 2 (control) needs the unlock. Outside initialization mode its bits 7, 6 and 4 keep their old values while the other bits update.
- R9: Slot 5 (wakeup) is writable only when unlocked and `wake_wr_ok` is 1. Slots 6 and 7 (alarms) are writable only when unlocked and `alarm_wr_ok` is 1.
- R10: Slot 9 (trim adjust) is writable only when unlocked and `adj_busy` is 0.
- R11: A write that changes no bit leaves the slot unchanged and makes `wr_drop` 1 for the following cycle only. Such a write is either refused by the rules above or aimed at an unmapped address. Key writes and partly allowed writes do not raise `wr_drop`.
- R12: `rd_data` shows the slot selected by `rd_addr` in the same cycle. The key slot 8 and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; relocks and clears everything |
| sys_rst | input | 1 | System reset, synchronous, active high; clears model slots only |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (4) | Write slot index |
| wr_data | input | DATA_W (32) | Write data |
| wake_wr_ok | input | 1 | Wakeup timer may be written |
| alarm_wr_ok | input | 1 | Alarm slots may be written |
| adj_busy | input | 1 | Trim adjustment in progress |
| rd_addr | input | ADDR_W (4) | Read slot index |
| rd_data | output | DATA_W (32) | Contents of the read slot |
| locked | output | 1 | 1 while protected slots are closed |
| init_active | output | 1 | Initialization mode flag (bit 0 of slot 3) |
| wr_drop | output | 1 | One-cycle pulse after a fully refused write |

## Verification
The hardest case to reach is a half-finished key sequence that is interrupted. The first key has been accepted, and the very next bus write is something other than the second key: a repeated first key, or a write to an unrelated slot. That next write must silently discard the progress. The bench drives these interleavings on purpose and then sends the second key alone, which must not open the lock. It also runs a system reset in the unlocked state to show the lock survives while the slots clear. Partial writes to the control and status slots use all-ones data, so that kept bits and updated bits differ in the read-back.

// File: rtl/rtcwp_pkg.sv
package rtcwp_pkg;

    // Slot map
    localparam int unsigned SLOT_TIME  = 0;
    localparam int unsigned SLOT_DATE  = 1;
    localparam int unsigned SLOT_CTRL  = 2;
    localparam int unsigned SLOT_STAT  = 3;
    localparam int unsigned SLOT_DIV   = 4;
    localparam int unsigned SLOT_WAKE  = 5;
    localparam int unsigned SLOT_ALMA  = 6;
    localparam int unsigned SLOT_ALMB  = 7;
    localparam int unsigned SLOT_KEY   = 8;
    localparam int unsigned SLOT_ADJ   = 9;
    localparam int unsigned SLOT_TAMP  = 10;
    localparam int unsigned NUM_FIXED  = 11;

    // Key bytes, in the order they must arrive
    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

    // Bit positions
    localparam int unsigned INIT_BIT       = 0;
    localparam logic [31:0] STAT_FREE_MASK = 32'h0000_7F00;
    localparam logic [31:0] CTRL_INIT_MASK = 32'h0000_00D0;

    typedef enum logic [3:0] {
        RK_TIME, RK_DATE, RK_CTRL, RK_STAT, RK_DIV, RK_WAKE, RK_ALMA,
        RK_ALMB, RK_KEY, RK_ADJ, RK_TAMP, RK_BKP, RK_NONE
    } reg_kind_e;

    typedef enum logic [1:0] {
        LK_IDLE, LK_HALF, LK_OPEN
    } lock_e;

    typedef struct packed {
        logic unlocked;
        logic init;
        logic wake_ok;
        logic alarm_ok;
        logic adj_busy;
    } gate_ctx_s;

    function automatic reg_kind_e classify(input int unsigned a, input int unsigned nbkp);
        reg_kind_e k;
        case (a)
            SLOT_TIME: k = RK_TIME;
            SLOT_DATE: k = RK_DATE;
            SLOT_CTRL: k = RK_CTRL;
            SLOT_STAT: k = RK_STAT;
            SLOT_DIV:  k = RK_DIV;
            SLOT_WAKE: k = RK_WAKE;
            SLOT_ALMA: k = RK_ALMA;
            SLOT_ALMB: k = RK_ALMB;
            SLOT_KEY:  k = RK_KEY;
            SLOT_ADJ:  k = RK_ADJ;
            SLOT_TAMP: k = RK_TAMP;
            default:   k = (a < NUM_FIXED + nbkp) ? RK_BKP : RK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/rtcwp_key_fsm.sv
module rtcwp_key_fsm
    import rtcwp_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst,
    input  logic       wr_en,
    input  logic       is_key,
    input  logic [7:0] key_byte,
    output lock_e      state,
    output logic       unlocked
);

    lock_e st_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            st_q <= LK_IDLE;
        end else if (wr_en) begin
            if (is_key) begin
                if (key_byte == KEY_FIRST)
                    st_q <= (st_q == LK_HALF) ? LK_IDLE : LK_HALF;
                else if (key_byte == KEY_SECOND && st_q == LK_HALF)
                    st_q <= LK_OPEN;
                else
                    st_q <= LK_IDLE;
            end else if (st_q == LK_HALF) begin
                st_q <= LK_IDLE;
            end
        end
    end

    assign state    = st_q;
    assign unlocked = (st_q == LK_OPEN);

    AST_OPEN_NEEDS_SECOND: assert property (@(posedge clk) disable iff (por_rst)
        $rose(st_q == LK_OPEN) |-> $past(wr_en && is_key && key_byte == KEY_SECOND)); // R3

    AST_BAD_KEY_RELOCKS: assert property (@(posedge clk) disable iff (por_rst)
        (wr_en && is_key && key_byte != KEY_FIRST && key_byte != KEY_SECOND) |=> (st_q == LK_IDLE)); // R4

    AST_HALF_ABANDONED: assert property (@(posedge clk) disable iff (por_rst)
        (st_q == LK_HALF && wr_en && !(is_key && key_byte == KEY_SECOND)) |=> (st_q == LK_IDLE)); // R5

endmodule

// File: rtl/rtcwp_policy.sv
module rtcwp_policy
    import rtcwp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  reg_kind_e          kind,
    input  gate_ctx_s          ctx,
    output logic [DATA_W-1:0]  mask,
    output logic               drop
);

    localparam logic [DATA_W-1:0] FULL      = '1;
    localparam logic [DATA_W-1:0] STAT_FREE = DATA_W'(STAT_FREE_MASK);
    localparam logic [DATA_W-1:0] CTRL_INIT = DATA_W'(CTRL_INIT_MASK);

    always_comb begin
        mask = '0;
        case (kind)
            RK_TIME, RK_DATE, RK_DIV:
                if (ctx.unlocked && ctx.init) mask = FULL;
            RK_CTRL:
                if (ctx.unlocked) mask = ctx.init ? FULL : (FULL & ~CTRL_INIT);
            RK_STAT:
                mask = ctx.unlocked ? FULL : STAT_FREE;
            RK_WAKE:
                if (ctx.unlocked && ctx.wake_ok) mask = FULL;
            RK_ALMA, RK_ALMB:
                if (ctx.unlocked && ctx.alarm_ok) mask = FULL;
            RK_ADJ:
                if (ctx.unlocked && !ctx.adj_busy) mask = FULL;
            RK_TAMP, RK_BKP:
                mask = FULL;
            default:
                mask = '0;
        endcase
        drop = (kind != RK_KEY) && (mask == '0);
    end

endmodule

// File: rtl/rtcwp_regfile.sv
module rtcwp_regfile
    import rtcwp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_SLOT = 15,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              init_bit
);

    logic [NUM_SLOT-1:0][DATA_W-1:0] mem;

    for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && waddr == ADDR_W'(i))
                mem[i] <= (mem[i] & ~wmask) | (wdata & wmask);
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < NUM_SLOT)
            rdata = mem[raddr];
    end

    assign init_bit = mem[SLOT_STAT][INIT_BIT];

    AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (we && wmask == '0) |=> $stable(mem)); // R11

endmodule

// File: rtl/rtcwp_gate.sv
module rtcwp_gate
    import rtcwp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_BKP = 4
) (
    input  logic                                    clk,
    input  logic                                    por_rst,
    input  logic                                    sys_rst,
    input  logic                                    wr_en,
    input  logic [$clog2(NUM_FIXED + NUM_BKP)-1:0]  wr_addr,
    input  logic [DATA_W-1:0]                       wr_data,
    input  logic                                    wake_wr_ok,
    input  logic                                    alarm_wr_ok,
    input  logic                                    adj_busy,
    input  logic [$clog2(NUM_FIXED + NUM_BKP)-1:0]  rd_addr,
    output logic [DATA_W-1:0]                       rd_data,
    output logic                                    locked,
    output logic                                    init_active,
    output logic                                    wr_drop
);

    localparam int NUM_SLOT = NUM_FIXED + NUM_BKP;
    localparam int ADDR_W   = $clog2(NUM_SLOT);
    localparam logic [DATA_W-1:0] STAT_FREE = DATA_W'(STAT_FREE_MASK);
    localparam logic [DATA_W-1:0] CTRL_INIT = DATA_W'(CTRL_INIT_MASK);

    reg_kind_e         kind;
    lock_e             lk_state;
    logic              unlocked;
    gate_ctx_s         ctx;
    logic [DATA_W-1:0] mask;
    logic              drop_now;
    logic              init_q;
    logic              drop_q;

    assign kind = classify(32'(wr_addr), NUM_BKP);

    rtcwp_key_fsm u_key (
        .clk      (clk),
        .por_rst  (por_rst),
        .wr_en    (wr_en),
        .is_key   (kind == RK_KEY),
        .key_byte (wr_data[7:0]),
        .state    (lk_state),
        .unlocked (unlocked)
    );

    always_comb begin
        ctx.unlocked = unlocked;
        ctx.init     = init_q;
        ctx.wake_ok  = wake_wr_ok;
        ctx.alarm_ok = alarm_wr_ok;
        ctx.adj_busy = adj_busy;
    end

    rtcwp_policy #(.DATA_W(DATA_W)) u_pol (
        .kind (kind),
        .ctx  (ctx),
        .mask (mask),
        .drop (drop_now)
    );

    rtcwp_regfile #(.DATA_W(DATA_W), .NUM_SLOT(NUM_SLOT), .ADDR_W(ADDR_W)) u_rf (
        .clk      (clk),
        .rst      (por_rst || sys_rst),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .wmask    (mask),
        .raddr    (rd_addr),
        .rdata    (rd_data),
        .init_bit (init_q)
    );

    always_ff @(posedge clk) begin
        if (por_rst || sys_rst)
            drop_q <= 1'b0;
        else
            drop_q <= wr_en && drop_now;
    end

    assign locked      = (lk_state != LK_OPEN);
    assign init_active = init_q;
    assign wr_drop     = drop_q;

    AST_POR_RELOCKS: assert property (@(posedge clk)
        $fell(por_rst) |-> locked); // R1

    AST_SYSRST_KEEPS_LOCK: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && !wr_en) |=> $stable(locked)); // R2

    AST_LOCKED_STAT_FREE: assert property (@(posedge clk) disable iff (por_rst)
        (locked && wr_en && kind == RK_STAT) |-> ((mask & ~STAT_FREE) == '0)); // R6

    AST_CTRL_INIT_HELD: assert property (@(posedge clk) disable iff (por_rst)
        (wr_en && kind == RK_CTRL && !init_active) |-> ((mask & CTRL_INIT) == '0)); // R8

    AST_TIME_NEEDS_INIT: assert property (@(posedge clk) disable iff (por_rst)
        (wr_en && (kind == RK_TIME || kind == RK_DATE || kind == RK_DIV) && !(init_active && !locked))
        |-> (mask == '0)); // R7

    AST_DROP_AFTER_WRITE: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        wr_drop |-> $past(wr_en)); // R11

endmodule

// File: tb/tb_rtcwp_gate.sv
module tb_rtcwp_gate;

    localparam int DW = 32;
    localparam int NB = 4;
    localparam int AW = 4;
    localparam int NSLOT = 15;

    logic          clk = 1'b0;
    logic          por_rst = 1'b1;
    logic          sys_rst = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wake_wr_ok = 1'b0;
    logic          alarm_wr_ok = 1'b0;
    logic          adj_busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          locked;
    logic          init_active;
    logic          wr_drop;

    rtcwp_gate #(.DATA_W(DW), .NUM_BKP(NB)) dut (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wake_wr_ok(wake_wr_ok),
        .alarm_wr_ok(alarm_wr_ok), .adj_busy(adj_busy), .rd_addr(rd_addr),
        .rd_data(rd_data), .locked(locked), .init_active(init_active),
        .wr_drop(wr_drop)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state: slots, key progress (0 idle, 1 first key seen, 2 open), drop flag
    logic [31:0] mreg [16];
    int          mst = 0;
    logic        mdrop = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        logic [31:0] er;
        er = (int'(rd_addr) < NSLOT) ? mreg[rd_addr] : 32'h0;
        chk(req, "locked", {31'b0, locked}, {31'b0, mst != 2});
        chk(req, "init_active", {31'b0, init_active}, {31'b0, mreg[3][0]});
        chk(req, "wr_drop", {31'b0, wr_drop}, {31'b0, mdrop});
        chk(req, "rd_data", rd_data, er);
    endtask

    function automatic logic [31:0] allowed(input int a);
        bit unl, ini;
        unl = (mst == 2);
        ini = mreg[3][0];
        if (a == 0 || a == 1 || a == 4) return (unl && ini) ? 32'hFFFF_FFFF : 32'h0;
        if (a == 2) return !unl ? 32'h0 : (ini ? 32'hFFFF_FFFF : 32'hFFFF_FF2F);
        if (a == 3) return unl ? 32'hFFFF_FFFF : 32'h0000_7F00;
        if (a == 5) return (unl && wake_wr_ok) ? 32'hFFFF_FFFF : 32'h0;
        if (a == 6 || a == 7) return (unl && alarm_wr_ok) ? 32'hFFFF_FFFF : 32'h0;
        if (a == 9) return (unl && !adj_busy) ? 32'hFFFF_FFFF : 32'h0;
        if (a >= 10 && a < NSLOT) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    task automatic model_clear(input bit por);
        for (int i = 0; i < 16; i++) mreg[i] = 32'h0;
        mdrop = 1'b0;
        if (por) mst = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string req);
        logic [31:0] m;
        bit nd;
        int nst;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; rd_addr = AW'(a);
        m = allowed(a);
        nd = (a != 8) && (m == 32'h0);
        nst = mst;
        if (a == 8) begin
            if (d[7:0] == 8'hCA) nst = (mst == 1) ? 0 : 1;
            else if (d[7:0] == 8'h53 && mst == 1) nst = 2;
            else nst = 0;
        end else if (mst == 1) begin
            nst = 0;
        end
        @(posedge clk);
        #1;
        if (a < NSLOT && a != 8) mreg[a] = (mreg[a] & ~m) | (d & m);
        mst = nst;
        mdrop = nd;
        compare(req);
    endtask

    task automatic peek(input int a, input string req);
        @(negedge clk);
        wr_en = 1'b0; rd_addr = AW'(a);
        @(posedge clk);
        #1;
        mdrop = 1'b0;
        compare(req);
    endtask

    task automatic do_reset(input bit por, input string req);
        @(negedge clk);
        wr_en = 1'b0;
        if (por) por_rst = 1'b1; else sys_rst = 1'b1;
        @(posedge clk);
        #1;
        model_clear(por);
        compare(req);
        @(negedge clk);
        por_rst = 1'b0; sys_rst = 1'b0;
    endtask

    task automatic unlock();
        wr(8, 32'h0000_00CA, "R3");
        wr(8, 32'h0000_0053, "R3");
    endtask

    initial begin
        model_clear(1);
        repeat (2) @(posedge clk);
        #1;
        compare("R1");
        @(negedge clk);
        por_rst = 1'b0;
        for (int i = 0; i < 16; i++) peek(i, "R1");

        // Locked: always-open slots and the free status bits
        wr(10, 32'hA5A5_0001, "R6");
        for (int i = 11; i < 15; i++) wr(i, 32'h1000_0000 + i, "R6");
        wr(3, 32'hFFFF_FFFF, "R6");
        wr(0, 32'h1234_5678, "R7");
        wr(2, 32'hFFFF_FFFF, "R8");
        wr(15, 32'hDEAD_BEEF, "R11");
        peek(15, "R12");
        peek(0, "R11");

        // Unlock with junk in upper key bits
        wr(8, 32'hFFFF_00CA, "R3");
        wr(8, 32'hABCD_0053, "R3");
        peek(8, "R12");
        wr(2, 32'hFFFF_FFFF, "R8");
        wr(0, 32'h0000_1111, "R7");
        wr(3, 32'h0000_0001, "R7");
        wr(0, 32'h0012_3456, "R7");
        wr(1, 32'h0022_0419, "R7");
        wr(4, 32'h007F_00FF, "R7");
        wr(2, 32'h0000_0000, "R8");
        wr(2, 32'h0000_00D0, "R8");

        // Status-gated slots
        wake_wr_ok = 1'b0; wr(5, 32'h0000_0AAA, "R9");
        wake_wr_ok = 1'b1; wr(5, 32'h0000_0BBB, "R9");
        alarm_wr_ok = 1'b0; wr(6, 32'h0101_0101, "R9");
        alarm_wr_ok = 1'b1; wr(6, 32'h0202_0202, "R9");
        wr(7, 32'h0303_0303, "R9");
        adj_busy = 1'b1; wr(9, 32'h0000_00F0, "R10");
        adj_busy = 1'b0; wr(9, 32'h0000_00F1, "R10");

        // Bad key relocks
        wr(8, 32'h0000_0011, "R4");
        wr(5, 32'h0000_0CCC, "R4");
        wr(3, 32'hFFFF_FFFF, "R6");
        unlock();
        wr(8, 32'h0000_00CA, "R4");
        wr(9, 32'h0000_0099, "R4");

        // Interrupted sequences
        wr(8, 32'h0000_00CA, "R5");
        wr(10, 32'h0000_0055, "R5");
        wr(8, 32'h0000_0053, "R5");
        wr(8, 32'h0000_00CA, "R5");
        wr(8, 32'h0000_00CA, "R5");
        wr(8, 32'h0000_0053, "R5");
        wr(8, 32'h0000_0053, "R5");
        unlock();

        // Back-to-back drops then idle
        wr(15, 32'h1, "R11");
        wr(15, 32'h2, "R11");
        peek(15, "R11");

        // System reset keeps the lock, power-on reset relocks
        wr(3, 32'h0000_0001, "R2");
        do_reset(0, "R2");
        peek(3, "R2");
        wr(9, 32'h0000_0077, "R2");
        wr(8, 32'h0000_00CA, "R2");
        do_reset(0, "R2");
        wr(8, 32'h0000_0053, "R2");
        do_reset(1, "R1");
        peek(0, "R1");
        wr(9, 32'h0000_0066, "R1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule